// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that copies a run of bytes from a source address range to a destination range over a 32-bit request/ready bus. Every move is a read at the source followed by a write at the destination. Software programs a control word, two addresses and a byte count through a small word-addressed register port, then sets the go bit. The channel signals completion through a done flag and an optional interrupt.

The source and destination each choose their own access width (byte, halfword, word or line) and whether their address increments or stays fixed. A fixed address suits a device data register and an incrementing address suits memory, so the same channel covers memory-to-device, device-to-memory, device-to-device and memory-to-memory moves. When the two widths differ, a 32-bit holding register packs narrow reads into wide writes or splits wide reads into narrow writes. Byte order is preserved throughout. Narrow data always travels on the byte lanes that match its address.

Top module: `dmac_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `bus_req` is low.
- R2: Register word offsets are 0 control, 1 source address, 2 destination address, 3 byte count and 4 status. The control word has these bits: bit0 go, bit1 abort, bit2 source fixed, bits[4:3] source size, bit5 destination fixed, bits[7:6] destination size, bit8 interrupt enable. A control read returns bits[8:2] as last written, with bit1 zero and bit0 showing busy.
- R3: Each unit is a source read and then a destination write. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay steady until `bus_ack`. A full transfer makes count/src_bytes reads and count/dst_bytes writes.
- R4: The size codes are 00 word (4 bytes), 01 byte, 10 halfword and 11 line. Line moves as 4-byte beats. An incrementing address advances by its access size after each access, and a fixed address never changes. After completion the address registers read base+count or base.
- R5: Byte lanes are little-endian: the byte at address a travels on `bus_wdata`/`bus_rdata` bits [8*a[1:0]+7 : 8*a[1:0]]. A write enables exactly the lanes its size covers starting at lane a[1:0].
- R6: When the source and destination sizes differ, the destination receives the source byte stream in address order.
- R7: The byte count counts bytes. It keeps CNT_W bits (default 24), and the bits above read zero. Each destination write lowers it by the destination size, and it reads zero after completion.
- R8: Completion sets status bit0 (done). Writing 1 to status bit0 clears it. `irq` is high exactly while done and interrupt enable are both set.
- R9: Go leaves the channel idle and sets status bit1 (configuration error) in either of two cases. The first is a byte count that is not a multiple of either side's unit (1, 2, 4 or 16 bytes for line). The second is an address not aligned to its side's access size (4 for line).
- R10: A control write with bit1 set stops any transfer by the next cycle without setting done, and clears the configuration error.
- R11: While busy, writes to the address, count and control-field registers and further go requests are ignored. Abort and the status clear still act.
- R12: Go with a zero byte count sets done without any bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | 32 | Write data, lane-aligned |
| bus_be | output | 4 | Write byte enables |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the channel with its defaults, ADDR_W=32 and CNT_W=24, so the count register's upper-bit masking can be seen at the port. It sweeps all sixteen source/destination size pairs crossed with all four fixed/incrementing combinations. It places narrow addresses at odd lane offsets and alternates zero and one wait states. With these settings every packing ratio, every byte lane and every static-address case reaches a byte memory model whose final contents the bench predicts arithmetically. Directed runs then cover configuration errors, aborts, zero counts and writes made while busy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int BUS_W  = 32;
    localparam int LANES  = BUS_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int NB_W   = LANE_W + 1;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_SRC    = 3'd1;
    localparam logic [2:0] REG_DST    = 3'd2;
    localparam logic [2:0] REG_COUNT  = 3'd3;
    localparam logic [2:0] REG_STATUS = 3'd4;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic       irq_en;
        xfer_size_e dst_size;
        logic       dst_fixed;
        xfer_size_e src_size;
        logic       src_fixed;
    } chan_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

    function automatic logic [NB_W-1:0] beat_bytes(xfer_size_e s);
        unique case (s)
            SZ_BYTE: return NB_W'(1);
            SZ_WORD: return NB_W'(2);
            default: return NB_W'(4);
        endcase
    endfunction

    function automatic logic [4:0] count_unit(xfer_size_e s);
        return (s == SZ_LINE) ? 5'd16 : 5'(beat_bytes(s));
    endfunction
endpackage

// File: rtl/dmac_lane_extract.sv
module dmac_lane_extract
    import dmac_pkg::*;
(
    input  logic [BUS_W-1:0]  word,
    input  logic [LANE_W-1:0] lane,
    input  logic [NB_W-1:0]   nbytes,
    output logic [BUS_W-1:0]  value
);
    logic [BUS_W-1:0] shifted;
    logic [BUS_W-1:0] keep;

    assign shifted = word >> {lane, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign keep[8*i +: 8] = (NB_W'(i) < nbytes) ? 8'hFF : 8'h00;
    end

    assign value = shifted & keep;
endmodule

// File: rtl/dmac_lane_insert.sv
module dmac_lane_insert
    import dmac_pkg::*;
(
    input  logic [BUS_W-1:0]  value,
    input  logic [LANE_W-1:0] lane,
    input  logic [NB_W-1:0]   nbytes,
    output logic [BUS_W-1:0]  word,
    output logic [LANES-1:0]  be
);
    logic [NB_W-1:0] first;
    logic [NB_W-1:0] last_ex;

    assign first   = {1'b0, lane};
    assign last_ex = first + nbytes;
    assign word    = value << {lane, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_be
        assign be[i] = (NB_W'(i) >= first) && (NB_W'(i) < last_ex);
    end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  xfer_size_e        src_size,
    input  xfer_size_e        dst_size,
    input  logic              src_fixed,
    input  logic              dst_fixed,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              ld_cnt,
    input  logic [BUS_W-1:0]  ld_data,
    output logic [ADDR_W-1:0] src_cur,
    output logic [ADDR_W-1:0] dst_cur,
    output logic [CNT_W-1:0]  cnt_cur,
    output logic              busy,
    output logic              done_pulse,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [LANES-1:0]  bus_be,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack
);
    seq_state_e        state_q;
    logic [BUS_W-1:0]  hold_q;
    logic [LANE_W-1:0] ptr_q;
    logic [NB_W-1:0]   sb, db, cb, rd_end, wr_end;
    logic [BUS_W-1:0]  rd_val, ins_word, hold_next, wr_val, wr_word;
    logic [LANES-1:0]  ins_be, wr_be;

    assign sb     = beat_bytes(src_size);
    assign db     = beat_bytes(dst_size);
    assign cb     = (sb > db) ? sb : db;
    assign rd_end = {1'b0, ptr_q} + sb;
    assign wr_end = {1'b0, ptr_q} + db;

    // source lanes -> right-aligned value -> holding register slot
    dmac_lane_extract u_rd_ext (
        .word(bus_rdata), .lane(src_cur[LANE_W-1:0]), .nbytes(sb), .value(rd_val));
    dmac_lane_insert u_hold_ins (
        .value(rd_val), .lane(ptr_q), .nbytes(sb), .word(ins_word), .be(ins_be));

    for (genvar i = 0; i < LANES; i++) begin : g_hold
        assign hold_next[8*i +: 8] = ins_be[i] ? ins_word[8*i +: 8] : hold_q[8*i +: 8];
    end

    // holding register slot -> right-aligned value -> destination lanes
    dmac_lane_extract u_hold_ext (
        .word(hold_q), .lane(ptr_q), .nbytes(db), .value(wr_val));
    dmac_lane_insert u_wr_ins (
        .value(wr_val), .lane(dst_cur[LANE_W-1:0]), .nbytes(db), .word(wr_word), .be(wr_be));

    assign busy      = (state_q != ST_IDLE);
    assign bus_req   = busy;
    assign bus_we    = (state_q == ST_WRITE);
    assign bus_addr  = bus_we ? dst_cur : src_cur;
    assign bus_wdata = bus_we ? wr_word : '0;
    assign bus_be    = bus_we ? wr_be : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hold_q     <= '0;
            ptr_q      <= '0;
            src_cur    <= '0;
            dst_cur    <= '0;
            cnt_cur    <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (ld_src) src_cur <= ld_data[ADDR_W-1:0];
            if (ld_dst) dst_cur <= ld_data[ADDR_W-1:0];
            if (ld_cnt) cnt_cur <= ld_data[CNT_W-1:0];
            if (abort) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start) begin
                        ptr_q <= '0;
                        if (cnt_cur == '0) done_pulse <= 1'b1;
                        else               state_q    <= ST_READ;
                    end
                    ST_READ: if (bus_ack) begin
                        hold_q <= hold_next;
                        if (!src_fixed) src_cur <= src_cur + ADDR_W'(sb);
                        if (rd_end == cb) begin
                            ptr_q   <= '0;
                            state_q <= ST_WRITE;
                        end else begin
                            ptr_q <= rd_end[LANE_W-1:0];
                        end
                    end
                    ST_WRITE: if (bus_ack) begin
                        if (!dst_fixed) dst_cur <= dst_cur + ADDR_W'(db);
                        cnt_cur <= cnt_cur - CNT_W'(db);
                        if (cnt_cur == CNT_W'(db)) begin
                            state_q    <= ST_IDLE;
                            done_pulse <= 1'b1;
                        end else if (wr_end == cb) begin
                            ptr_q   <= '0;
                            state_q <= ST_READ;
                        end else begin
                            ptr_q <= wr_end[LANE_W-1:0];
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_be,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              irq
);
    chan_cfg_t         cfg_q, cfg_new;
    logic              done_q, err_q, busy, done_pulse;
    logic [ADDR_W-1:0] src_cur, dst_cur;
    logic [CNT_W-1:0]  cnt_cur;
    logic              ctrl_wr, abort_wr, go_wr, cfg_bad, start;
    logic [NB_W-1:0]   sb_new, db_new;
    logic [4:0]        su_new, du_new;

    assign cfg_new  = chan_cfg_t'(reg_wdata[8:2]);
    assign ctrl_wr  = reg_we && (reg_addr == REG_CTRL);
    assign abort_wr = ctrl_wr && reg_wdata[1];
    assign go_wr    = ctrl_wr && !reg_wdata[1] && reg_wdata[0] && !busy;

    // configuration check on the fields written together with go
    assign sb_new  = beat_bytes(cfg_new.src_size);
    assign db_new  = beat_bytes(cfg_new.dst_size);
    assign su_new  = count_unit(cfg_new.src_size);
    assign du_new  = count_unit(cfg_new.dst_size);
    assign cfg_bad = ((cnt_cur[4:0] & (su_new - 5'd1)) != '0)
                  || ((cnt_cur[4:0] & (du_new - 5'd1)) != '0)
                  || ((src_cur[NB_W-1:0] & (sb_new - NB_W'(1))) != '0)
                  || ((dst_cur[NB_W-1:0] & (db_new - NB_W'(1))) != '0);
    assign start   = go_wr && !cfg_bad;

    dmac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .abort(abort_wr),
        .src_size(cfg_q.src_size), .dst_size(cfg_q.dst_size),
        .src_fixed(cfg_q.src_fixed), .dst_fixed(cfg_q.dst_fixed),
        .ld_src(reg_we && (reg_addr == REG_SRC) && !busy),
        .ld_dst(reg_we && (reg_addr == REG_DST) && !busy),
        .ld_cnt(reg_we && (reg_addr == REG_COUNT) && !busy),
        .ld_data(reg_wdata),
        .src_cur(src_cur), .dst_cur(dst_cur), .cnt_cur(cnt_cur),
        .busy(busy), .done_pulse(done_pulse),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (ctrl_wr && !abort_wr && !busy) cfg_q <= cfg_new;
            if (abort_wr)                      err_q <= 1'b0;
            else if (go_wr && cfg_bad)         err_q <= 1'b1;
            if (done_pulse)                    done_q <= 1'b1;
            else if (reg_we && (reg_addr == REG_STATUS) && reg_wdata[0])
                                               done_q <= 1'b0;
        end
    end

    assign irq = done_q && cfg_q.irq_en;

    always_comb begin
        unique case (reg_addr)
            REG_CTRL:   reg_rdata = {23'b0, cfg_q, 1'b0, busy};
            REG_SRC:    reg_rdata = 32'(src_cur);
            REG_DST:    reg_rdata = 32'(dst_cur);
            REG_COUNT:  reg_rdata = 32'(cnt_cur);
            REG_STATUS: reg_rdata = {29'b0, busy, err_q, done_q};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [3:0]        bus_be,
    input logic              abort_wr,
    input logic              busy,
    input logic              err_q,
    input logic              done_q,
    input logic [CNT_W-1:0]  cnt_cur,
    input xfer_size_e        dst_size
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack && !abort_wr |=> bus_req && $stable(bus_we)
            && $stable(bus_addr) && $stable(bus_wdata)); // R3

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_we); // R3

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (dst_size == SZ_BYTE) |-> $countones(bus_be) == 1); // R5

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> cnt_cur == '0); // R7

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !busy && !bus_req); // R9

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
        abort_wr |=> !bus_req && !$rose(done_q)); // R10
endmodule

bind dmac_channel dmac_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .abort_wr(abort_wr), .busy(busy), .err_q(err_q), .done_q(done_q),
    .cnt_cur(cnt_cur), .dst_size(cfg_q.dst_size));

// File: tb/dmac_channel_test.sv
module dmac_channel_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int acc_cnt = 0;
    int wait_cfg = 0;
    int wait_cnt = 0;
    bit finished = 0;
    logic [7:0] mem [256];
    logic [7:0] init_mem [256];
    logic [7:0] exp_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq));

    // byte memory responder, little-endian lanes
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wait_cnt < wait_cfg) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                bus_ack  = 1'b1;
                acc_cnt++;
                for (int i = 0; i < 4; i++) begin
                    if (bus_we && bus_be[i])
                        mem[{bus_addr[7:2], 2'(i)}] = bus_wdata[8*i +: 8];
                    bus_rdata[8*i +: 8] = mem[{bus_addr[7:2], 2'(i)}];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        int n = 0;
        repeat (2) @(negedge clk);
        st = 32'h4;
        while (st[2] && n < 5000) begin
            reg_rd(3'd4, st);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(!st[2], "R3 transfer ends", st, 0);
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            init_mem[i] = 8'(i * 37 + 11);
            mem[i] = init_mem[i];
            exp_mem[i] = init_mem[i];
        end
    endtask

    function automatic int nbytes(int sz);
        return (sz == 1) ? 1 : (sz == 2) ? 2 : 4;
    endfunction

    task automatic mem_check(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {mem[first], 8'h0, 8'(first)}, {exp_mem[first], 8'h0, 8'(first)});
    endtask

    task automatic run_case(input int ss, input int ds, input int sf, input int df);
        int sb = nbytes(ss);
        int db = nbytes(ds);
        int cnt = 32;
        int s = 'h10 + ((ss == 1) ? 3 : (ss == 2) ? 2 : 0);
        int d = 'h80 + ((ds == 1) ? 1 : (ds == 2) ? 2 : 0);
        int ie = sf;
        int acc0;
        logic [31:0] ctl, rv;
        logic [7:0] stream [32];
        fill_mem();
        for (int i = 0; i < cnt; i++)
            stream[i] = sf ? init_mem[s + (i % sb)] : init_mem[s + i];
        if (df) for (int j = 0; j < db; j++) exp_mem[d + j] = stream[cnt - db + j];
        else    for (int i = 0; i < cnt; i++) exp_mem[d + i] = stream[i];
        ctl = 32'((ie << 8) | (ds << 6) | (df << 5) | (ss << 3) | (sf << 2));
        wait_cfg = (ss + ds) % 2;
        reg_wr(3'd1, 32'(s));
        reg_wr(3'd2, 32'(d));
        reg_wr(3'd3, 32'(cnt));
        acc0 = acc_cnt;
        reg_wr(3'd0, ctl | 32'h1);
        wait_idle();
        // R5 lanes, R6 packing order
        mem_check((ss == ds) ? "R5 lane placement" : "R6 packing order");
        chk(acc_cnt - acc0 == cnt / sb + cnt / db, "R3 access count", acc_cnt - acc0, cnt / sb + cnt / db);
        reg_rd(3'd3, rv); chk(rv == 0, "R7 residue zero", rv, 0);
        reg_rd(3'd1, rv); chk(rv == 32'(sf ? s : s + cnt), "R4 source advance", rv, sf ? s : s + cnt);
        reg_rd(3'd2, rv); chk(rv == 32'(df ? d : d + cnt), "R4 dest advance", rv, df ? d : d + cnt);
        reg_rd(3'd0, rv); chk(rv == ctl, "R2 control readback", rv, ctl);
        reg_rd(3'd4, rv); chk(rv == 32'h1, "R8 done set", rv, 1);
        chk(irq == 1'(ie), "R8 irq gated", 32'(irq), ie);
        reg_wr(3'd4, 32'h1);
        reg_rd(3'd4, rv); chk(rv == 0, "R8 done cleared", rv, 0);
        chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 0);
    endtask

    initial begin
        repeat (2000 * CLK_PERIOD) #(100);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int acc0;
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), rv);
            chk(rv == 0, "R1 register reset", rv, 0);
        end
        chk(!irq && !bus_req, "R1 outputs idle", {irq, bus_req}, 0);

        // R7 upper count bits
        reg_wr(3'd3, 32'hAB000010);
        reg_rd(3'd3, rv); chk(rv == 32'h10, "R7 count width", rv, 32'h10);

        // exhaustive size and address-mode sweep
        for (int ss = 0; ss < 4; ss++)
            for (int ds = 0; ds < 4; ds++)
                for (int sf = 0; sf < 2; sf++)
                    for (int df = 0; df < 2; df++)
                        run_case(ss, ds, sf, df);
        wait_cfg = 0;

        // R9 count not a multiple of word size
        fill_mem();
        reg_wr(3'd1, 32'h10); reg_wr(3'd2, 32'h80); reg_wr(3'd3, 32'd6);
        acc0 = acc_cnt;
        reg_wr(3'd0, 32'h1);
        repeat (2) @(negedge clk);
        reg_rd(3'd4, rv); chk(rv == 32'h2, "R9 count error", rv, 2);
        reg_rd(3'd3, rv); chk(rv == 6, "R9 count untouched", rv, 6);
        chk(acc_cnt == acc0, "R9 no access", acc_cnt, acc0);
        // R10 abort clears error
        reg_wr(3'd0, 32'h2);
        reg_rd(3'd4, rv); chk(rv == 0, "R10 error cleared", rv, 0);
        // R9 misaligned halfword source
        reg_wr(3'd1, 32'h11); reg_wr(3'd3, 32'd8);
        reg_wr(3'd0, 32'h1 | (2 << 3) | (2 << 6));
        reg_rd(3'd4, rv); chk(rv == 32'h2, "R9 alignment error", rv, 2);
        reg_wr(3'd0, 32'h2);
        // R9 line count not a multiple of 16
        reg_wr(3'd1, 32'h10);
        reg_wr(3'd0, 32'h1 | (3 << 3));
        reg_rd(3'd4, rv); chk(rv == 32'h2, "R9 line unit error", rv, 2);
        chk(acc_cnt == acc0, "R9 still no access", acc_cnt, acc0);
        mem_check("R9 memory untouched");
        reg_wr(3'd0, 32'h2);

        // R12 zero count
        reg_wr(3'd3, 32'd0);
        reg_wr(3'd0, 32'h1);
        repeat (2) @(negedge clk);
        reg_rd(3'd4, rv); chk(rv == 32'h1, "R12 zero count done", rv, 1);
        chk(acc_cnt == acc0, "R12 no bus access", acc_cnt, acc0);
        reg_wr(3'd4, 32'h1);

        // R10 abort mid transfer
        reg_wr(3'd3, 32'd64);
        reg_wr(3'd0, 32'h1 | (1 << 3) | (1 << 6));
        repeat (10) @(negedge clk);
        reg_wr(3'd0, 32'h2);
        chk(!bus_req, "R10 request dropped", 32'(bus_req), 0);
        acc0 = acc_cnt;
        repeat (10) @(negedge clk);
        chk(acc_cnt == acc0, "R10 no further access", acc_cnt, acc0);
        reg_rd(3'd4, rv); chk(rv == 0, "R10 no done", rv, 0);
        reg_rd(3'd3, rv); chk(rv != 0 && rv < 64, "R10 partial residue", rv, 1);

        // R11 writes while busy ignored
        fill_mem();
        for (int i = 0; i < 32; i++) exp_mem['h80 + i] = init_mem['h10 + i];
        reg_wr(3'd1, 32'h10); reg_wr(3'd2, 32'h80); reg_wr(3'd3, 32'd32);
        reg_wr(3'd0, 32'h1);
        reg_wr(3'd2, 32'h40);
        reg_wr(3'd3, 32'd4);
        reg_wr(3'd0, 32'h1 | (1 << 3));
        wait_idle();
        mem_check("R11 busy writes ignored");
        reg_rd(3'd2, rv); chk(rv == 32'hA0, "R11 dest unchanged", rv, 32'hA0);
        reg_rd(3'd0, rv); chk(rv == 0, "R11 control unchanged", rv, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule